// File: doc/BRIEF.md
# PWM-Locked Third-Order Sinc Decimator

This block turns the single-bit stream of an isolated sigma-delta modulator into signed multi-bit current samples. Three wrap-around integrators run on every clock, one modulator bit per clock. Three differentiators run once per decimation window. The window boundaries come from a decimation counter, and a PWM synchronization pulse reloads that counter with a programmable phase. As a result the filter's impulse response keeps a fixed position inside the PWM carrier period. The control loop then takes the sample whose response is centred on the mean-current instant.

A PWM period that holds a whole number N of windows produces N samples. Each sample is tagged with its position in the period. Once the counter is locked, a sync pulse that matches the counter's own phase changes nothing: the filter state is never cleared, so the output sequence stays continuous.

Top module: `pwm_locked_sinc3`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `sample_valid` is 0, `sample_out` is 0 and `sample_idx` is 0.
- R2: After reset the first three window boundaries give no strobe. With no sync and ratio R, the first `sample_valid` follows clock edge 4R−1, counting the first edge with `rst` low as edge 0, and carries index 3.
- R3: With no sync, boundaries fall on edges m with m mod R = R−1. Each `sample_valid` pulse lasts one cycle, and consecutive pulses are R edges apart.
- R4: A constant input of ones settles to +R³ and a constant input of zeros settles to −R³, up to and including R = 256, with no overflow of the output word.
- R5: A bit of 1 counts as +1 and a bit of 0 as −1. For a boundary at edge m, `sample_out` equals the sum over k of h[k]·x[m−3−k], where h is the triple convolution of a length-R box and bits before reset count as 0. This holds whenever the last three windows were each R edges long.
- R6: A `pwm_sync` sampled at edge t loads `lock_phase` = o (0 ≤ o < R) into the counter. The next boundary falls on edge t+R−o, and its sample has index 0.
- R7: Indices count 0, 1, 2, … from the last sync, or from reset if there has been none. A boundary on the same edge as a sync keeps the old index. With o = 0 and a sync every N·R edges, each period yields indices 0 to N−1.
- R8: Periodic sync pulses that agree with the running phase leave the samples equal to the R5 convolution.
- R9: Without sync, the index stops at 2^IDX_W−1 and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; one bitstream bit per edge |
| rst | input | 1 | Synchronous active-high reset |
| mod_bit | input | 1 | Modulator output bit |
| dec_ratio | input | LOG2_MAX_RATIO+1 | Decimation ratio R, 2 to 2^LOG2_MAX_RATIO |
| lock_phase | input | LOG2_MAX_RATIO+1 | Counter value loaded on sync, below R |
| pwm_sync | input | 1 | Single-cycle PWM carrier synchronization pulse |
| sample_out | output | 3·LOG2_MAX_RATIO+2 | Signed filtered sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| sample_idx | output | IDX_W | Position of the sample within the PWM period |

## Verification
The hardest state to reach from the ports is a sync that lands between boundaries while the filter is already in steady operation. It shortens one window, and that is the case where the realignment arithmetic and the index clearing must agree. The bench warms the filter with a pseudo-random bitstream and then issues the sync on a chosen edge that is away from a boundary. It then measures the edge of the next strobe from its own edge counter. A second scenario applies sync pulses with a period of exactly N windows and compares every sample against a bench-side sinc3 convolution of the recorded bits. This shows that the locked sync pulses do not disturb the filter.

// File: rtl/pwmsinc_pkg.sv
package pwmsinc_pkg;

    // Accumulator width: 3*log2(R) bits of gain, one sign bit and one for +R^3
    function automatic int acc_width(input int log2_ratio);
        return 3 * log2_ratio + 2;
    endfunction

    // Bitstream symbol to signed unit step
    function automatic logic signed [1:0] bit_step(input logic b);
        return b ? 2'sd1 : -2'sd1;
    endfunction

    typedef enum logic [1:0] {
        WARM_0    = 2'd0,
        WARM_1    = 2'd1,
        WARM_2    = 2'd2,
        WARM_DONE = 2'd3
    } warm_e;

    typedef struct packed {
        logic tick;       // window boundary this cycle
        logic warm_done;  // settling windows already passed
    } decim_evt_t;

endpackage

// File: rtl/sinc3_integrators.sv
module sinc3_integrators #(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bit_in,
    output logic signed [ACC_W-1:0] acc_out
);
    import pwmsinc_pkg::*;

    localparam int STAGES = 3;

    logic signed [ACC_W-1:0] acc_q [STAGES];
    logic signed [ACC_W-1:0] feed  [STAGES+1];

    assign feed[0] = ACC_W'(bit_step(bit_in));

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        assign feed[g+1] = acc_q[g];
        always_ff @(posedge clk) begin
            if (rst) acc_q[g] <= '0;
            else     acc_q[g] <= acc_q[g] + feed[g];
        end
    end

    assign acc_out = acc_q[STAGES-1];

    // R5: first stage moves by exactly one unit per clock
    p_unit_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((acc_q[0] - $past(acc_q[0]) == ACC_W'(1)) ||
                         (acc_q[0] - $past(acc_q[0]) == -ACC_W'(1))));

endmodule

// File: rtl/sinc3_decim_ctrl.sv
module sinc3_decim_ctrl #(
    parameter int RATIO_W = 9,
    parameter int IDX_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [RATIO_W-1:0]            ratio,
    input  logic [RATIO_W-1:0]            phase_load,
    input  logic                          sync,
    output pwmsinc_pkg::decim_evt_t       evt,
    output logic [IDX_W-1:0]              idx
);
    import pwmsinc_pkg::*;

    localparam logic [RATIO_W-1:0] ONE     = RATIO_W'(1);
    localparam logic [IDX_W-1:0]   IDX_TOP = '1;

    logic [RATIO_W-1:0] cnt_q;
    logic [IDX_W-1:0]   idx_q;
    warm_e              warm_q;
    logic               tick;

    assign tick = (cnt_q >= ratio - ONE);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (sync) cnt_q <= phase_load;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)                           idx_q <= '0;
        else if (sync)                     idx_q <= '0;
        else if (tick && idx_q != IDX_TOP) idx_q <= idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                              warm_q <= WARM_0;
        else if (tick && warm_q != WARM_DONE) warm_q <= warm_e'(warm_q + 2'd1);
    end

    always_comb begin
        evt.tick      = tick;
        evt.warm_done = (warm_q == WARM_DONE);
    end
    assign idx = idx_q;

    // R6: sync reloads the phase offset
    p_sync_load_r6: assert property (@(posedge clk) disable iff (rst)
        sync |=> cnt_q == $past(phase_load));
    // R3: free-running counter wraps after a boundary
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !sync) |=> cnt_q == '0);
    // R7: index restarts after a sync
    p_idx_clear_r7: assert property (@(posedge clk) disable iff (rst)
        sync |=> idx_q == '0);
    // R9: saturated index holds while no sync arrives
    p_idx_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (idx_q == IDX_TOP && !sync) |=> idx_q == IDX_TOP);

endmodule

// File: rtl/sinc3_combs.sv
module sinc3_combs #(
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic signed [ACC_W-1:0] acc_in,
    output logic signed [ACC_W-1:0] y
);
    localparam int STAGES = 3;

    logic signed [ACC_W-1:0] dly_q  [STAGES];
    logic signed [ACC_W-1:0] stg_in [STAGES+1];
    logic signed [ACC_W-1:0] y_q;

    assign stg_in[0] = acc_in;

    for (genvar g = 0; g < STAGES; g++) begin : g_diff
        assign stg_in[g+1] = stg_in[g] - dly_q[g];
        always_ff @(posedge clk) begin
            if (rst)       dly_q[g] <= '0;
            else if (tick) dly_q[g] <= stg_in[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       y_q <= '0;
        else if (tick) y_q <= stg_in[STAGES];
    end

    assign y = y_q;

    // R3: sample holds between boundaries
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(y_q));

endmodule

// File: rtl/pwm_locked_sinc3.sv
module pwm_locked_sinc3 #(
    parameter int LOG2_MAX_RATIO = 8,
    parameter int IDX_W          = 6,
    localparam int RATIO_W       = LOG2_MAX_RATIO + 1,
    localparam int ACC_W         = pwmsinc_pkg::acc_width(LOG2_MAX_RATIO)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mod_bit,
    input  logic [RATIO_W-1:0]      dec_ratio,
    input  logic [RATIO_W-1:0]      lock_phase,
    input  logic                    pwm_sync,
    output logic signed [ACC_W-1:0] sample_out,
    output logic                    sample_valid,
    output logic [IDX_W-1:0]        sample_idx
);
    import pwmsinc_pkg::*;

    logic signed [ACC_W-1:0] acc3;
    decim_evt_t              evt;
    logic [IDX_W-1:0]        cur_idx;
    logic                    valid_q;
    logic [IDX_W-1:0]        idx_q;

    sinc3_integrators #(.ACC_W(ACC_W)) u_integ (
        .clk    (clk),
        .rst    (rst),
        .bit_in (mod_bit),
        .acc_out(acc3)
    );

    sinc3_decim_ctrl #(.RATIO_W(RATIO_W), .IDX_W(IDX_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ratio     (dec_ratio),
        .phase_load(lock_phase),
        .sync      (pwm_sync),
        .evt       (evt),
        .idx       (cur_idx)
    );

    sinc3_combs #(.ACC_W(ACC_W)) u_comb (
        .clk   (clk),
        .rst   (rst),
        .tick  (evt.tick),
        .acc_in(acc3),
        .y     (sample_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= evt.tick && evt.warm_done;
            if (evt.tick) idx_q <= cur_idx;
        end
    end

    assign sample_valid = valid_q;
    assign sample_idx   = idx_q;

    // R3: strobe is a single cycle (ratio of at least 2)
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);
    // R2: no strobe before the settling windows have passed
    p_warm_r2: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> $past(evt.warm_done));

endmodule

// File: tb/test_pwm_locked_sinc3.sv
module test_pwm_locked_sinc3;

    localparam int L2   = 8;
    localparam int RW   = L2 + 1;
    localparam int AW   = 3 * L2 + 2;
    localparam int IW   = 6;
    localparam int HSZ  = 4096;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 mod_bit = 1'b0;
    logic [RW-1:0]        dec_ratio = RW'(8);
    logic [RW-1:0]        lock_phase = '0;
    logic                 pwm_sync = 1'b0;
    logic signed [AW-1:0] sample_out;
    logic                 sample_valid;
    logic [IW-1:0]        sample_idx;

    pwm_locked_sinc3 #(.LOG2_MAX_RATIO(L2), .IDX_W(IW)) i_pwm_locked_sinc3 (
        .clk(clk), .rst(rst), .mod_bit(mod_bit), .dec_ratio(dec_ratio),
        .lock_phase(lock_phase), .pwm_sync(pwm_sync),
        .sample_out(sample_out), .sample_valid(sample_valid), .sample_idx(sample_idx)
    );

    always #4 clk = ~clk;   // 125 MHz

    int        errors = 0;
    int        checks = 0;
    int        mcount = 0;
    int        hist [HSZ];
    longint    h [3*256];
    int        cur_r = 8;
    int        src_mode = 0;   // 0 zeros, 1 ones, 2 pseudo-random
    logic [15:0] lfsr = 16'hACE1;
    int        sync_per = 0;
    int        sync_base = 0;
    bit        conv_on = 1'b0;
    string     conv_tag = "R5";
    int        log_n = 0;
    int        log_m   [256];
    longint    log_v   [256];
    int        log_idx [256];
    bit        done = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bench-side sinc3 weights: box * box * box of length R
    task automatic set_weights(input int r);
        cur_r = r;
        for (int k = 0; k < 3*r-2; k++) begin
            longint s = 0;
            for (int c = 0; c < r; c++) begin
                int j = k - c;
                if (j >= 0 && j <= 2*r-2)
                    s += (j + 1 < 2*r - 1 - j) ? longint'(j + 1) : longint'(2*r - 1 - j);
            end
            h[k] = s;
        end
    endtask

    function automatic longint conv_at(input int m);
        longint s = 0;
        for (int k = 0; k < 3*cur_r-2; k++) begin
            int j = m - 3 - k;
            if (j >= 0) s += h[k] * longint'(hist[j % HSZ]);
        end
        return s;
    endfunction

    always @(posedge clk) begin
        if (!rst) begin
            hist[mcount % HSZ] = mod_bit ? 1 : -1;
            mcount++;
        end
    end

    always @(negedge clk) begin
        if (!rst && sample_valid) begin
            if (log_n < 256) begin
                log_m[log_n]   = mcount - 1;
                log_v[log_n]   = longint'(sample_out);
                log_idx[log_n] = int'(sample_idx);
                log_n++;
            end
            if (conv_on)
                chk(longint'(sample_out) == conv_at(mcount - 1), conv_tag,
                    longint'(sample_out), conv_at(mcount - 1));
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            case (src_mode)
                0: mod_bit = 1'b0;
                1: mod_bit = 1'b1;
                default: begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    mod_bit = lfsr[0];
                end
            endcase
            pwm_sync = (sync_per > 0 && mcount >= sync_base &&
                        ((mcount - sync_base) % sync_per) == 0);
        end
    endtask

    task automatic do_reset(input int r, input int mode);
        @(negedge clk);
        rst = 1'b1; pwm_sync = 1'b0; sync_per = 0; conv_on = 1'b0;
        dec_ratio = RW'(r); src_mode = mode;
        set_weights(r);
        repeat (3) @(negedge clk);
        mcount = 0; log_n = 0;
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(sample_valid == 1'b0, "R1 valid", longint'(sample_valid), 0);
        chk(sample_out == '0, "R1 out", longint'(sample_out), 0);
        chk(sample_idx == '0, "R1 idx", longint'(sample_idx), 0);
        do_reset(8, 0);
        @(negedge clk);
        chk(sample_valid == 1'b0 && sample_out == '0 && sample_idx == '0,
            "R1 first cycle", longint'(sample_out), 0);
    endtask

    task automatic t_warmup_spacing();
        do_reset(8, 2);
        run(80);
        chk(log_n > 0 && log_m[0] == 31, "R2 first strobe edge", longint'(log_m[0]), 31);
        chk(log_idx[0] == 3, "R2 first index", longint'(log_idx[0]), 3);
        chk(log_n == 6, "R3 strobe count", longint'(log_n), 6);
        for (int i = 1; i < log_n; i++)
            chk(log_m[i] - log_m[i-1] == 8, "R3 spacing", longint'(log_m[i] - log_m[i-1]), 8);
    endtask

    task automatic t_dc(input int r);
        longint full = longint'(r) * r * r;
        do_reset(r, 1);
        run(5*r);
        chk(log_n > 0 && log_v[log_n-1] == full, "R4 ones", log_v[log_n-1], full);
        src_mode = 0; log_n = 0;
        run(5*r);
        chk(log_n > 0 && log_v[log_n-1] == -full, "R4 zeros", log_v[log_n-1], -full);
    endtask

    task automatic t_conv();
        do_reset(16, 2);
        run(64);
        conv_tag = "R5"; conv_on = 1'b1;
        run(320);
        conv_on = 1'b0;
    endtask

    task automatic t_sync_offset();
        int t;
        do_reset(16, 2);
        lock_phase = RW'(5);
        run(100);
        while ((mcount % 16) != 3) run(1);
        @(negedge clk);
        mod_bit = 1'b1; t = mcount; pwm_sync = 1'b1; log_n = 0;
        run(40);
        chk(log_n >= 2 && log_m[0] == t + 11, "R6 first boundary", longint'(log_m[0]), longint'(t + 11));
        chk(log_idx[0] == 0, "R6 index", longint'(log_idx[0]), 0);
        chk(log_m[1] == t + 27, "R6 next spacing", longint'(log_m[1]), longint'(t + 27));
        lock_phase = '0;
    endtask

    task automatic t_period_lock();
        do_reset(8, 2);
        run(50);
        sync_base = mcount + 2; sync_per = 40;
        run(40);
        log_n = 0; conv_tag = "R8"; conv_on = 1'b1;
        run(120);
        conv_on = 1'b0; sync_per = 0; pwm_sync = 1'b0;
        chk(log_n == 15, "R7 samples per three periods", longint'(log_n), 15);
        for (int i = 0; i < log_n; i++) begin
            int e = (((log_m[i] - sync_base) / 8) - 1) % 5;
            chk(log_idx[i] == e, "R7 index", longint'(log_idx[i]), longint'(e));
        end
    endtask

    task automatic t_idx_sat();
        do_reset(8, 0);
        run(70*8);
        chk(log_n > 0 && log_idx[log_n-1] == 63, "R9 saturated index",
            longint'(log_idx[log_n-1]), 63);
        chk(log_n > 61 && log_idx[60] == 63 && log_idx[59] == 62, "R9 reaches top",
            longint'(log_idx[60]), 63);
    endtask

    initial begin
        t_reset_state();
        t_warmup_spacing();
        t_dc(8);
        t_dc(16);
        t_dc(256);
        t_conv();
        t_sync_offset();
        t_period_lock();
        t_idx_sat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule